// File: doc/BRIEF.md
# Dual-channel UART register bank

This block is the host-facing control layer of a two-channel serial port. A narrow host bus (3-bit address, channel select, read strobe, write strobe and a data byte) reaches two separate register sets, one for each channel. Each set holds a line control byte, a modem control byte, an interrupt-enable nibble, a scratch byte and a 16-bit baud divisor. One auxiliary byte is shared by both channels. The serial shifters, FIFOs and baud counters sit outside. This block drives their control fields and takes in their status.

The shared auxiliary byte has two jobs. Its bit 0 turns on broadcast writes, in which one host write lands in the addressed register of every channel while reads still come from the selected channel. Its bits 2:1 choose what each channel's multifunction pin shows. The bank also applies per-channel controls to the pins: break forces the transmit pin low, and the modem-control bits drive the active-low terminal-ready pin.

Top module: `duart_regbank`

## Requirements
- R1: A synchronous reset, with `rst` high for at least two clocks, clears every register. Afterwards every readable location returns 0, `divisor`, `line_fmt`, `irq_en` and `tx_load` are 0, and `tx_pin`, `dtr_n` and `mf_pin` are 1.
- R2: The register map is decoded from `addr`. Address 3 is the 8-bit line control register. Address 4 is the modem control register. With line control bit 7 clear, address 1 is the interrupt-enable register and address 2 is the scratch byte. Addresses 5 to 7 read 0 and ignore writes. A write changes the register at the clock edge that samples `wr_en`. `rdata` is loaded at the edge that samples `rd_en` and holds between reads.
- R3: While a channel's line control bit 7 is 1, address 0 reaches that channel's divisor low byte and address 1 reaches its high byte. `divisor` presents {high, low}.
- R4: A write to address 0 while line control bit 7 is 0 raises that channel's `tx_load` for exactly one cycle after the write edge, with `tx_byte` equal to the written data. A read of address 0 in that state returns the channel's `rx_byte_in`.
- R5: While broadcast is off, a write reaches only the channel named by `ch_sel`.
- R6: While auxiliary bit 0 is 1, a single write updates the addressed register in both channels. Reads still return the register of the channel named by `ch_sel`. A read in the same cycle as a write returns the value from before the write.
- R7: The auxiliary byte is a single shared register. It sits at address 2 of any channel whose line control bit 7 is 1, it can be written through either channel, and it reads back identically through both.
- R8: During a broadcast write to addresses 0 to 2, each channel decodes the write with its own line control bit 7. So the same write can load one channel's divisor and send a byte from the other channel.
- R9: One cycle after a channel's line control bit 6 is 1, its `tx_pin` is 0 whatever `tx_serial_in` is. When the bit is 0, `tx_pin` follows `tx_serial_in` one cycle late.
- R10: `dtr_n` of a channel is the inverse of its modem control bit 0, one cycle late.
- R11: Auxiliary bits 2:1 set each channel's `mf_pin`, one cycle late: 00 gives the inverse of modem control bit 3, 01 gives `baud_clk_in`, 10 gives the inverse of `rx_ready_in`, and 11 gives a constant 1.
- R12: Reserved bits read 0 and ignore writes. These are interrupt-enable bits 7:4, modem control bits 7:5 and auxiliary bits 7:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| ch_sel | input | 1 | Channel select for reads and non-broadcast writes |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, loads `rdata` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_byte_in | input | 2x8 | Received byte from each channel's receiver |
| tx_serial_in | input | 2 | Serial stream from each channel's transmitter |
| baud_clk_in | input | 2 | Baud clock of each channel |
| rx_ready_in | input | 2 | Receive data ready, active high, per channel |
| tx_pin | output | 2 | Transmit pins after break control |
| dtr_n | output | 2 | Active-low terminal-ready pins |
| mf_pin | output | 2 | Multifunction pins |
| tx_load | output | 2 | One-cycle load pulse to each transmitter |
| tx_byte | output | 2x8 | Byte that goes with `tx_load` |
| divisor | output | 2x16 | Baud divisor of each channel |
| line_fmt | output | 2x6 | Line control bits 5:0 of each channel |
| irq_en | output | 2x4 | Interrupt-enable bits of each channel |

## Verification
A broadcast write and a read can land on the same edge, because both use the one address and channel bus. The bench raises `wr_en` and `rd_en` together on a modem-control address during broadcast. It expects the old value in `rdata` and the new value on the next read of each channel. The bench also sends one broadcast write to address 0 while the two channels hold different line control bit 7 values. That single write must produce both a divisor update and a `tx_load` pulse, and each is judged at the ports.

// File: rtl/duart_pkg.sv
package duart_pkg;
  // register addresses (low three are banked by line control bit 7)
  localparam logic [2:0] ADR_DATA  = 3'd0;
  localparam logic [2:0] ADR_IEN   = 3'd1;
  localparam logic [2:0] ADR_AUX   = 3'd2;
  localparam logic [2:0] ADR_LINE  = 3'd3;
  localparam logic [2:0] ADR_MODEM = 3'd4;

  // implemented widths of partially reserved registers
  localparam int IEN_BITS = 4;
  localparam int MCR_BITS = 5;
  localparam int AUX_BITS = 3;
  localparam int FMT_BITS = 6;

  // bit positions the pin logic decodes
  localparam int LC_DIVSEL = 7;
  localparam int LC_BREAK  = 6;
  localparam int MC_TREADY = 0;
  localparam int MC_USROUT = 3;
  localparam int AX_BCAST  = 0;

  typedef enum logic [1:0] {
    MF_USROUT = 2'b00,
    MF_BAUD   = 2'b01,
    MF_RXRDY  = 2'b10,
    MF_IDLE   = 2'b11
  } mf_sel_t;
endpackage

// File: rtl/duart_chan_regs.sv
module duart_chan_regs
  import duart_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_hit,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  input  logic [DW-1:0]       rx_byte,
  input  logic [AUX_BITS-1:0] aux,
  output logic [DW-1:0]       lcr,
  output logic [MCR_BITS-1:0] mcr,
  output logic [IEN_BITS-1:0] ien,
  output logic [2*DW-1:0]     div,
  output logic                tx_load,
  output logic [DW-1:0]       tx_byte,
  output logic                aux_req,
  output logic [DW-1:0]       rd_val
);
  logic [DW-1:0] scr;
  logic          divsel;

  assign divsel  = lcr[LC_DIVSEL];
  assign aux_req = wr_hit && (addr == AW'(ADR_AUX)) && divsel;

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr     <= '0;
      mcr     <= '0;
      ien     <= '0;
      div     <= '0;
      scr     <= '0;
      tx_load <= 1'b0;
      tx_byte <= '0;
    end else begin
      tx_load <= 1'b0;
      if (wr_hit) begin
        case (addr)
          AW'(ADR_DATA): begin
            if (divsel) div[DW-1:0] <= wdata;
            else begin
              tx_load <= 1'b1;
              tx_byte <= wdata;
            end
          end
          AW'(ADR_IEN): begin
            if (divsel) div[2*DW-1:DW] <= wdata;
            else        ien <= wdata[IEN_BITS-1:0];
          end
          AW'(ADR_AUX):   if (!divsel) scr <= wdata;
          AW'(ADR_LINE):  lcr <= wdata;
          AW'(ADR_MODEM): mcr <= wdata[MCR_BITS-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      AW'(ADR_DATA):  rd_val = divsel ? div[DW-1:0] : rx_byte;
      AW'(ADR_IEN):   rd_val = divsel ? div[2*DW-1:DW] : DW'(ien);
      AW'(ADR_AUX):   rd_val = divsel ? DW'(aux) : scr;
      AW'(ADR_LINE):  rd_val = lcr;
      AW'(ADR_MODEM): rd_val = DW'(mcr);
      default:        rd_val = '0;
    endcase
  end
endmodule

// File: rtl/duart_pin_drive.sv
module duart_pin_drive
  import duart_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    brk,
  input  logic    tready,
  input  logic    usrout,
  input  mf_sel_t mf_sel,
  input  logic    tx_serial,
  input  logic    baud_clk,
  input  logic    rx_ready,
  output logic    tx_pin,
  output logic    dtr_n,
  output logic    mf_pin
);
  logic mf_nxt;

  always_comb begin
    case (mf_sel)
      MF_USROUT: mf_nxt = !usrout;
      MF_BAUD:   mf_nxt = baud_clk;
      MF_RXRDY:  mf_nxt = !rx_ready;
      default:   mf_nxt = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pin <= 1'b1;
      dtr_n  <= 1'b1;
      mf_pin <= 1'b1;
    end else begin
      tx_pin <= brk ? 1'b0 : tx_serial;
      dtr_n  <= !tready;
      mf_pin <= mf_nxt;
    end
  end
endmodule

// File: rtl/duart_regbank.sv
module duart_regbank
  import duart_pkg::*;
#(
  parameter  int NCH = 2,
  parameter  int DW  = 8,
  parameter  int AW  = 3,
  localparam int CSW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [AW-1:0]                 addr,
  input  logic [CSW-1:0]                ch_sel,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [DW-1:0]                 wdata,
  output logic [DW-1:0]                 rdata,
  input  logic [NCH-1:0][DW-1:0]        rx_byte_in,
  input  logic [NCH-1:0]                tx_serial_in,
  input  logic [NCH-1:0]                baud_clk_in,
  input  logic [NCH-1:0]                rx_ready_in,
  output logic [NCH-1:0]                tx_pin,
  output logic [NCH-1:0]                dtr_n,
  output logic [NCH-1:0]                mf_pin,
  output logic [NCH-1:0]                tx_load,
  output logic [NCH-1:0][DW-1:0]        tx_byte,
  output logic [NCH-1:0][2*DW-1:0]      divisor,
  output logic [NCH-1:0][FMT_BITS-1:0]  line_fmt,
  output logic [NCH-1:0][IEN_BITS-1:0]  irq_en
);
  logic [NCH-1:0]                wr_hit;
  logic [NCH-1:0]                aux_req;
  logic [NCH-1:0][DW-1:0]        rd_v;
  logic [NCH-1:0][DW-1:0]        lcr_q;
  logic [NCH-1:0][MCR_BITS-1:0]  mcr_q;
  logic [AUX_BITS-1:0]           aux_q;
  mf_sel_t                       mf_sel;

  assign mf_sel = mf_sel_t'(aux_q[2:1]);

  // broadcast widens the write target to every channel
  always_comb begin
    for (int c = 0; c < NCH; c++)
      wr_hit[c] = wr_en && (aux_q[AX_BCAST] || (ch_sel == CSW'(c)));
  end

  always_ff @(posedge clk) begin
    if (rst)           aux_q <= '0;
    else if (|aux_req) aux_q <= wdata[AUX_BITS-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_v[ch_sel];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    duart_chan_regs #(.DW(DW), .AW(AW)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_hit  (wr_hit[c]),
      .addr    (addr),
      .wdata   (wdata),
      .rx_byte (rx_byte_in[c]),
      .aux     (aux_q),
      .lcr     (lcr_q[c]),
      .mcr     (mcr_q[c]),
      .ien     (irq_en[c]),
      .div     (divisor[c]),
      .tx_load (tx_load[c]),
      .tx_byte (tx_byte[c]),
      .aux_req (aux_req[c]),
      .rd_val  (rd_v[c])
    );

    duart_pin_drive u_pins (
      .clk       (clk),
      .rst       (rst),
      .brk       (lcr_q[c][LC_BREAK]),
      .tready    (mcr_q[c][MC_TREADY]),
      .usrout    (mcr_q[c][MC_USROUT]),
      .mf_sel    (mf_sel),
      .tx_serial (tx_serial_in[c]),
      .baud_clk  (baud_clk_in[c]),
      .rx_ready  (rx_ready_in[c]),
      .tx_pin    (tx_pin[c]),
      .dtr_n     (dtr_n[c]),
      .mf_pin    (mf_pin[c])
    );

    assign line_fmt[c] = lcr_q[c][FMT_BITS-1:0];
  end
endmodule

// File: rtl/duart_regbank_chk.sv
module duart_regbank_chk
  import duart_pkg::*;
#(
  parameter  int NCH = 2,
  parameter  int DW  = 8,
  parameter  int AW  = 3,
  localparam int CSW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic                         clk,
  input logic                         rst,
  input logic [AW-1:0]                addr,
  input logic [CSW-1:0]               ch_sel,
  input logic                         wr_en,
  input logic                         rd_en,
  input logic [DW-1:0]                wdata,
  input logic [DW-1:0]                rdata,
  input logic [NCH-1:0]               tx_pin,
  input logic [NCH-1:0]               dtr_n,
  input logic [NCH-1:0]               tx_load,
  input logic [NCH-1:0][DW-1:0]       lcr_q,
  input logic [NCH-1:0][MCR_BITS-1:0] mcr_q,
  input logic [AUX_BITS-1:0]          aux_q
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R9: a break bit held in the previous cycle pulls the pin low
    a_r9_break_low: assert property (@(posedge clk) disable iff (rst)
      $past(lcr_q[c][LC_BREAK]) |-> !tx_pin[c]);

    // R10: terminal-ready pin mirrors the inverted control bit one cycle late
    a_r10_dtr_follows: assert property (@(posedge clk) disable iff (rst)
      dtr_n[c] == !$past(mcr_q[c][MC_TREADY]));

    // R4: a load pulse only follows a data-address write with divisor access off
    a_r4_load_origin: assert property (@(posedge clk) disable iff (rst)
      tx_load[c] |-> ($past(wr_en) && ($past(addr) == AW'(ADR_DATA))
                      && !$past(lcr_q[c][LC_DIVSEL])));

    // R5: a non-broadcast write to another channel leaves this line control alone
    a_r5_other_stable: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !aux_q[AX_BCAST] && (ch_sel != CSW'(c)) && (addr == AW'(ADR_LINE)))
      |=> $stable(lcr_q[c]));

    // R6: a broadcast modem-control write lands in every channel
    a_r6_bcast_modem: assert property (@(posedge clk) disable iff (rst)
      (wr_en && aux_q[AX_BCAST] && (addr == AW'(ADR_MODEM)))
      |=> (mcr_q[c] == $past(wdata[MCR_BITS-1:0])));
  end

  // R12: reserved auxiliary bits always read back as zero
  a_r12_aux_rsvd: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == AW'(ADR_AUX)) && lcr_q[ch_sel][LC_DIVSEL])
    |=> (rdata[DW-1:AUX_BITS] == '0));
endmodule

bind duart_regbank duart_regbank_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .ch_sel  (ch_sel),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .wdata   (wdata),
  .rdata   (rdata),
  .tx_pin  (tx_pin),
  .dtr_n   (dtr_n),
  .tx_load (tx_load),
  .lcr_q   (lcr_q),
  .mcr_q   (mcr_q),
  .aux_q   (aux_q)
);

// File: tb/sim_duart_regbank.sv
`timescale 1ns/1ps
module sim_duart_regbank;
  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       addr = '0;
  logic [0:0]       ch_sel = '0;
  logic             wr_en = 1'b0;
  logic             rd_en = 1'b0;
  logic [7:0]       wdata = '0;
  logic [7:0]       rdata;
  logic [1:0][7:0]  rx_byte_in = {8'h3C, 8'hA5};
  logic [1:0]       tx_serial_in = 2'b11;
  logic [1:0]       baud_clk_in = 2'b00;
  logic [1:0]       rx_ready_in = 2'b00;
  logic [1:0]       tx_pin, dtr_n, mf_pin, tx_load;
  logic [1:0][7:0]  tx_byte;
  logic [1:0][15:0] divisor;
  logic [1:0][5:0]  line_fmt;
  logic [1:0][3:0]  irq_en;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  duart_regbank u0 (
    .clk(clk), .rst(rst), .addr(addr), .ch_sel(ch_sel), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .rx_byte_in(rx_byte_in),
    .tx_serial_in(tx_serial_in), .baud_clk_in(baud_clk_in),
    .rx_ready_in(rx_ready_in), .tx_pin(tx_pin), .dtr_n(dtr_n),
    .mf_pin(mf_pin), .tx_load(tx_load), .tx_byte(tx_byte),
    .divisor(divisor), .line_fmt(line_fmt), .irq_en(irq_en)
  );

  typedef struct packed {
    logic       rd;
    logic       ch;
    logic [2:0] a;
    logic [7:0] v;
    logic [3:0] r;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    {1'b0, 1'b0, 3'd3, 8'h03, 4'd2},   // R2 write line control A
    {1'b1, 1'b0, 3'd3, 8'h03, 4'd2},   // R2
    {1'b1, 1'b1, 3'd3, 8'h00, 4'd5},   // R5 channel B untouched
    {1'b0, 1'b1, 3'd2, 8'h5A, 4'd2},   // R2 scratch B
    {1'b1, 1'b1, 3'd2, 8'h5A, 4'd2},   // R2
    {1'b1, 1'b0, 3'd2, 8'h00, 4'd5},   // R5 scratch A untouched
    {1'b0, 1'b0, 3'd1, 8'hFF, 4'd12},  // R12 interrupt enable A
    {1'b1, 1'b0, 3'd1, 8'h0F, 4'd12},  // R12 upper nibble reserved
    {1'b0, 1'b0, 3'd4, 8'hFF, 4'd12},  // R12 modem control A
    {1'b1, 1'b0, 3'd4, 8'h1F, 4'd12},  // R12 bits 7:5 reserved
    {1'b0, 1'b0, 3'd6, 8'h77, 4'd2},   // R2 unused address
    {1'b1, 1'b0, 3'd6, 8'h00, 4'd2},   // R2
    {1'b0, 1'b0, 3'd3, 8'h83, 4'd3},   // R3 divisor access on A
    {1'b0, 1'b0, 3'd0, 8'h34, 4'd3},   // R3 divisor low
    {1'b0, 1'b0, 3'd1, 8'h12, 4'd3},   // R3 divisor high
    {1'b1, 1'b0, 3'd0, 8'h34, 4'd3},   // R3
    {1'b1, 1'b0, 3'd1, 8'h12, 4'd3},   // R3
    {1'b1, 1'b1, 3'd0, 8'h3C, 4'd4},   // R4 receive byte B
    {1'b1, 1'b1, 3'd1, 8'h00, 4'd5},   // R5 interrupt enable B untouched
    {1'b1, 1'b0, 3'd3, 8'h83, 4'd2}    // R2
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic ch, input logic [2:0] a, input logic [7:0] d);
    ch_sel = ch; addr = a; wdata = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic ch, input logic [2:0] a, input logic [7:0] e, input string tag);
    ch_sel = ch; addr = a; rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    check(32'(rdata), 32'(e), tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) step();
    rst = 1'b0;
    step();
    // R1 reset state
    check(32'(rdata), 0, "R1 rdata");
    check(32'(dtr_n), 32'h3, "R1 dtr_n");
    check(32'(mf_pin), 32'h3, "R1 mf_pin");
    check(32'(tx_pin), 32'h3, "R1 tx_pin");
    check(32'(tx_load), 0, "R1 tx_load");
    check(32'(divisor), 0, "R1 divisor");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) rd_chk(VEC[i].ch, VEC[i].a, VEC[i].v, $sformatf("R%0d vec%0d", VEC[i].r, i));
      else           wr(VEC[i].ch, VEC[i].a, VEC[i].v);
    end
    check(32'(dtr_n), 32'h2, "R10 dtr A low");
    check(32'(mf_pin), 32'h2, "R11 user output A");
    check(32'(divisor[0]), 32'h1234, "R3 divisor A");
    check(32'(line_fmt[0]), 32'h03, "R2 line format A");
    check(32'(irq_en[0]), 32'hF, "R2 irq enable A");

    // R7 shared auxiliary register, R6 broadcast
    wr(0, 3'd2, 8'hFB);
    rd_chk(0, 3'd2, 8'h03, "R7 aux via A");
    rd_chk(1, 3'd2, 8'h5A, "R6 read follows select");
    wr(1, 3'd3, 8'h80);
    rd_chk(0, 3'd3, 8'h80, "R6 broadcast line control");
    rd_chk(1, 3'd2, 8'h03, "R7 aux via B");
    wr(1, 3'd2, 8'h02);
    rd_chk(0, 3'd2, 8'h02, "R7 aux written via B");
    wr(1, 3'd3, 8'h00);
    rd_chk(0, 3'd3, 8'h80, "R5 single-channel write");
    wr(0, 3'd2, 8'h03);

    // R8 per-channel decode during broadcast
    wr(0, 3'd0, 8'h77);
    check(32'(tx_load), 32'h2, "R8 load pulse on B only");
    check(32'(tx_byte[1]), 32'h77, "R4 tx byte");
    check(32'(divisor[0]), 32'h1277, "R8 divisor A low");
    step();
    check(32'(tx_load), 0, "R4 one-cycle pulse");
    check(32'(divisor[1]), 0, "R8 divisor B untouched");
    wr(0, 3'd2, 8'h01);
    rd_chk(1, 3'd2, 8'h01, "R8 scratch B");
    rd_chk(0, 3'd2, 8'h01, "R8 aux via A");

    // R6 broadcast modem write; same-cycle read returns old value
    wr(0, 3'd4, 8'h08);
    rd_chk(1, 3'd4, 8'h08, "R6 modem B");
    check(32'(mf_pin), 0, "R11 user output both");
    check(32'(dtr_n), 32'h3, "R10 dtr both high");
    ch_sel = 1; addr = 3'd4; wdata = 8'h00; wr_en = 1'b1; rd_en = 1'b1;
    step();
    wr_en = 1'b0; rd_en = 1'b0;
    check(32'(rdata), 32'h08, "R6 read beside write");
    rd_chk(1, 3'd4, 8'h00, "R6 new value B");
    rd_chk(0, 3'd4, 8'h00, "R6 new value A");
    check(32'(mf_pin), 32'h3, "R11 user output cleared");

    // R9 break
    wr(0, 3'd2, 8'h00);
    wr(1, 3'd3, 8'h40);
    step();
    check(32'(tx_pin), 32'h1, "R9 break B");
    tx_serial_in = 2'b10;
    step(); step();
    check(32'(tx_pin), 32'h0, "R9 break holds");
    tx_serial_in = 2'b11;
    step(); step();
    check(32'(tx_pin), 32'h1, "R9 A follows");
    wr(1, 3'd3, 8'h00);
    step();
    check(32'(tx_pin), 32'h3, "R9 break released");

    // R11 multifunction select
    baud_clk_in = 2'b01;
    wr(0, 3'd2, 8'h02);
    step();
    check(32'(mf_pin), 32'h1, "R11 baud");
    baud_clk_in = 2'b10;
    step(); step();
    check(32'(mf_pin), 32'h2, "R11 baud toggled");
    rx_ready_in = 2'b01;
    wr(0, 3'd2, 8'h04);
    step();
    check(32'(mf_pin), 32'h2, "R11 receive ready");
    wr(0, 3'd2, 8'h06);
    step();
    check(32'(mf_pin), 32'h3, "R11 reserved code");
    baud_clk_in = 2'b00; rx_ready_in = 2'b11;
    step(); step();
    check(32'(mf_pin), 32'h3, "R11 reserved holds");
    wr(0, 3'd2, 8'hFF);
    rd_chk(0, 3'd2, 8'h07, "R12 aux reserved");

    // R1 reset mid-run
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    step();
    rd_chk(0, 3'd3, 8'h00, "R1 line control");
    rd_chk(0, 3'd1, 8'h00, "R1 irq enable");
    check(32'(divisor), 0, "R1 divisor");
    check(32'(dtr_n), 32'h3, "R1 dtr");
    check(32'(mf_pin), 32'h3, "R1 mf");
    wr(0, 3'd3, 8'h80);
    rd_chk(1, 3'd3, 8'h00, "R1 broadcast cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule